// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Selectable Write Policy

This block sits between a 32-bit load/store port and a word-wide backing memory. It keeps sixteen one-word lines, each with a tag, a valid bit and a dirty bit. Two control inputs pick its mode. In write-back mode a store hit stays in the cache and marks the line dirty. In write-through mode every store is also sent to memory and lines stay clean. In disabled mode every access goes straight to memory and the array is left untouched.

Two maintenance commands act on the whole array. The discard command drops every line at once, and dirty data is lost. The flush command walks the lines in ascending index order and writes each dirty word to its own address. When the walk ends it drops every line. While a miss, eviction, memory write or flush is in progress, the block holds `busy` high. Each accepted request or command ends with a one-cycle `rsp_valid`.

Top module: `dcache_wb`

## Requirements
- R1: After reset every line is invalid, `busy`, `rsp_valid` and `mem_req` are low, and the first read of any address fetches it from memory.
- R2: With `ctl_disable`=0 and `ctl_wback`=1 (write-back), a store that hits or allocates updates only the line and marks it dirty. No memory write occurs, and later loads return the stored word.
- R3: A load miss whose target line holds dirty data first writes that word to its own address, then reads the requested word.
- R4: With `ctl_disable`=0 and `ctl_wback`=0 (write-through), every store writes memory, a store miss does not allocate, and no line becomes dirty, so a later eviction writes nothing.
- R5: With `ctl_disable`=1 (any `ctl_wback`), loads read memory and stores write memory. The array is neither read nor changed.
- R6: A `cmd_inval` pulse while idle invalidates all lines with no memory traffic, so dirty data is discarded.
- R7: A `cmd_flush` pulse writes every dirty line to memory in ascending index order. Only after that does it invalidate every line, clean ones included.
- R8: A request whose address bits [1:0] are not 00 completes with `rsp_err`=1 and makes no memory access and no change to the array. Memory addresses are always word aligned.
- R9: `mem_req` with its address, direction and write data stays stable until `mem_ack`. `busy` is high during any memory access, and `rsp_valid` lasts exactly one cycle.
- R10: The line index is address bits [5:2] and the tag is bits [31:6]. Addresses with equal index and different tags replace each other, while different indices coexist.
- R11: A load miss returns the fetched word and installs it as a clean line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_disable | input | 1 | 1: bypass the array for every access |
| ctl_wback | input | 1 | 1: write-back, 0: write-through (when not disabled) |
| cmd_inval | input | 1 | Invalidate all lines, discarding dirty data |
| cmd_flush | input | 1 | Write back dirty lines, then invalidate all |
| req_valid | input | 1 | Access request, held until `rsp_valid` |
| req_we | input | 1 | 1: store, 0: load |
| req_addr | input | 32 | Byte address of the access |
| req_wdata | input | 32 | Store data |
| busy | output | 1 | Operation in progress; new requests not accepted |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completed request was misaligned |
| rsp_rdata | output | 32 | Load result, valid with `rsp_valid` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1: memory write, 0: memory read |
| mem_addr | output | 32 | Word-aligned memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory completion, one cycle |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |

## Verification
The bench builds the block with its default parameters: 32-bit addresses and data and a 4-bit index, giving sixteen lines. With this size, the bench can fill chosen lines by hand, put a dirty line and a clean line on one index through two tags, and walk the full flush sequence. The bench's memory model counts reads and writes and records write addresses, so evictions, bypasses and the flush order are all visible at the memory port.

// File: rtl/dc_pkg.sv
// Package: shared types for the data cache.
// Assumes nothing beyond IEEE 1800-2017 enums.
package dc_pkg;

    // Controller states; one memory transaction per memory state.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_EVICT = 3'd1,
        ST_FILL  = 3'd2,
        ST_MWR   = 3'd3,
        ST_MRD   = 3'd4,
        ST_FSCAN = 3'd5,
        ST_FWB   = 3'd6,
        ST_DONE  = 3'd7
    } dc_state_e;

endpackage

// File: rtl/dc_store.sv
// Module: tag, data, valid and dirty storage for a direct-mapped cache.
// One combinational read port, one line write port, a dirty-clear port
// and a global clear. Global clear wins over any write in the same cycle.
// Assumes the caller never writes and dirty-clears the same line at once.
module dc_store #(
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 26,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic              rd_dirty,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_dirty,
    input  logic              cln_en,
    input  logic [IDX_W-1:0]  cln_idx,
    input  logic              clr_all
);
    localparam int LINES = 1 << IDX_W;

    logic              valid_q [LINES];
    logic              dirty_q [LINES];
    logic [TAG_W-1:0]  tag_q   [LINES];
    logic [DATA_W-1:0] data_q  [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        // Line status bits: reset, global clear, write, dirty clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
                dirty_q[g] <= 1'b0;
            end else if (clr_all) begin
                valid_q[g] <= 1'b0;
                dirty_q[g] <= 1'b0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                valid_q[g] <= 1'b1;
                dirty_q[g] <= wr_dirty;
            end else if (cln_en && cln_idx == IDX_W'(g)) begin
                dirty_q[g] <= 1'b0;
            end
        end

        // Line payload: tag and word, no reset needed behind valid.
        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == IDX_W'(g)) begin
                tag_q[g]  <= wr_tag;
                data_q[g] <= wr_data;
            end
        end
    end

    // Read port: select the addressed line.
    always_comb begin
        rd_valid = valid_q[rd_idx];
        rd_dirty = dirty_q[rd_idx];
        rd_tag   = tag_q[rd_idx];
        rd_data  = data_q[rd_idx];
    end

endmodule

// File: rtl/dc_lookup.sv
// Module: hit and victim classification for the line being read.
// Assumes the read port already points at the request's index.
module dc_lookup #(
    parameter int TAG_W = 26
) (
    input  logic [TAG_W-1:0] req_tag,
    input  logic             rd_valid,
    input  logic             rd_dirty,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             hit,
    output logic             victim_dirty
);
    // Compare stored tag and flag a line that must be saved first.
    always_comb begin
        hit          = rd_valid && (rd_tag == req_tag);
        victim_dirty = rd_valid && rd_dirty;
    end

endmodule

// File: rtl/dc_ctrl.sv
// Module: access and flush controller for the data cache.
// Accepts one request or command while idle, runs the memory handshake
// (request held until a one-cycle ack), walks lines in ascending order
// for a flush and ends every operation with one DONE cycle.
// Assumes word lines (4 bytes) and that the core holds its request
// until rsp_valid. Mode inputs are latched when a request is accepted.
module dc_ctrl
    import dc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4,
    parameter int TAG_W  = ADDR_W - IDX_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_disable,
    input  logic              ctl_wback,
    input  logic              cmd_inval,
    input  logic              cmd_flush,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [IDX_W-1:0]  rd_idx,
    output logic [TAG_W-1:0]  cur_tag,
    input  logic [TAG_W-1:0]  rd_tag,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              rd_valid,
    input  logic              rd_dirty,
    input  logic              hit,
    input  logic              victim_dirty,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [TAG_W-1:0]  wr_tag,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_dirty,
    output logic              cln_en,
    output logic [IDX_W-1:0]  cln_idx,
    output logic              clr_all
);
    localparam int LINES = 1 << IDX_W;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINES - 1);

    dc_state_e         state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              we_q;
    logic              err_q;
    logic [DATA_W-1:0] rdata_q;
    logic [IDX_W-1:0]  walk_q;

    logic [ADDR_W-1:0] cur_addr;
    logic [IDX_W-1:0]  cur_idx;
    logic              idle_req;
    logic              aligned;
    logic              walking;

    // Address in focus: live request while idle, latched one otherwise.
    always_comb begin
        cur_addr = (state_q == ST_IDLE) ? req_addr : addr_q;
        cur_idx  = cur_addr[IDX_W+1:2];
        cur_tag  = cur_addr[ADDR_W-1:IDX_W+2];
        walking  = (state_q == ST_FSCAN) || (state_q == ST_FWB);
        rd_idx   = walking ? walk_q : cur_idx;
        aligned  = (req_addr[1:0] == 2'b00);
        idle_req = (state_q == ST_IDLE) && !cmd_flush && !cmd_inval && req_valid;
    end

    // Array update requests derived from the current state.
    always_comb begin
        wr_en    = 1'b0;
        wr_idx   = cur_idx;
        wr_tag   = cur_tag;
        wr_data  = req_wdata;
        wr_dirty = 1'b0;
        cln_en   = 1'b0;
        cln_idx  = walk_q;
        clr_all  = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (!cmd_flush && cmd_inval) begin
                    clr_all = 1'b1;
                end else if (idle_req && aligned && !ctl_disable && req_we) begin
                    if (hit) begin
                        wr_en    = 1'b1;
                        wr_dirty = ctl_wback;
                    end else if (ctl_wback && !victim_dirty) begin
                        wr_en    = 1'b1;
                        wr_dirty = 1'b1;
                    end
                end
            end
            ST_EVICT: begin
                if (mem_ack && we_q) begin
                    wr_en    = 1'b1;
                    wr_data  = wdata_q;
                    wr_dirty = 1'b1;
                end
            end
            ST_FILL: begin
                if (mem_ack) begin
                    wr_en   = 1'b1;
                    wr_data = mem_rdata;
                end
            end
            ST_FSCAN: begin
                if (!(rd_valid && rd_dirty) && walk_q == LAST_IDX) begin
                    clr_all = 1'b1;
                end
            end
            ST_FWB: begin
                if (mem_ack) begin
                    cln_en  = 1'b1;
                    clr_all = (walk_q == LAST_IDX);
                end
            end
            default: ;
        endcase
    end

    // Memory port: one transaction per memory state, held until ack.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = addr_q;
        mem_wdata = wdata_q;
        case (state_q)
            ST_EVICT, ST_FWB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {rd_tag, rd_idx, 2'b00};
                mem_wdata = rd_data;
            end
            ST_MWR: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            ST_FILL, ST_MRD: begin
                mem_req = 1'b1;
            end
            default: ;
        endcase
    end

    // Sequencer: accept work, step through memory states, walk lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            we_q    <= 1'b0;
            err_q   <= 1'b0;
            rdata_q <= '0;
            walk_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (cmd_flush) begin
                        err_q   <= 1'b0;
                        walk_q  <= '0;
                        state_q <= ST_FSCAN;
                    end else if (cmd_inval) begin
                        err_q   <= 1'b0;
                        state_q <= ST_DONE;
                    end else if (req_valid) begin
                        addr_q  <= req_addr;
                        wdata_q <= req_wdata;
                        we_q    <= req_we;
                        err_q   <= !aligned;
                        if (!aligned) begin
                            state_q <= ST_DONE;
                        end else if (ctl_disable) begin
                            state_q <= req_we ? ST_MWR : ST_MRD;
                        end else if (!req_we) begin
                            if (hit) begin
                                rdata_q <= rd_data;
                                state_q <= ST_DONE;
                            end else begin
                                state_q <= victim_dirty ? ST_EVICT : ST_FILL;
                            end
                        end else if (hit) begin
                            state_q <= ctl_wback ? ST_DONE : ST_MWR;
                        end else if (ctl_wback) begin
                            state_q <= victim_dirty ? ST_EVICT : ST_DONE;
                        end else begin
                            state_q <= ST_MWR;
                        end
                    end
                end
                ST_EVICT: begin
                    if (mem_ack) state_q <= we_q ? ST_DONE : ST_FILL;
                end
                ST_FILL, ST_MRD: begin
                    if (mem_ack) begin
                        rdata_q <= mem_rdata;
                        state_q <= ST_DONE;
                    end
                end
                ST_MWR: begin
                    if (mem_ack) state_q <= ST_DONE;
                end
                ST_FSCAN: begin
                    if (rd_valid && rd_dirty) begin
                        state_q <= ST_FWB;
                    end else if (walk_q == LAST_IDX) begin
                        state_q <= ST_DONE;
                    end else begin
                        walk_q <= walk_q + 1'b1;
                    end
                end
                ST_FWB: begin
                    if (mem_ack) begin
                        if (walk_q == LAST_IDX) begin
                            state_q <= ST_DONE;
                        end else begin
                            walk_q  <= walk_q + 1'b1;
                            state_q <= ST_FSCAN;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Core-side status outputs.
    always_comb begin
        busy      = (state_q != ST_IDLE);
        rsp_valid = (state_q == ST_DONE);
        rsp_err   = err_q;
        rsp_rdata = rdata_q;
    end

endmodule

// File: rtl/dcache_wb.sv
// Module: top of the direct-mapped data cache with run-time write policy.
// Wires the storage, the hit logic and the controller together.
// Assumes 4-byte words, so the lowest two address bits are the offset.
module dcache_wb #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_disable,
    input  logic              ctl_wback,
    input  logic              cmd_inval,
    input  logic              cmd_flush,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int TAG_W = ADDR_W - IDX_W - 2;

    logic [IDX_W-1:0]  rd_idx;
    logic [TAG_W-1:0]  cur_tag;
    logic [TAG_W-1:0]  rd_tag;
    logic [DATA_W-1:0] rd_data;
    logic              rd_valid;
    logic              rd_dirty;
    logic              hit;
    logic              victim_dirty;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [TAG_W-1:0]  wr_tag;
    logic [DATA_W-1:0] wr_data;
    logic              wr_dirty;
    logic              cln_en;
    logic [IDX_W-1:0]  cln_idx;
    logic              clr_all;

    dc_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (rd_idx),
        .rd_valid (rd_valid),
        .rd_dirty (rd_dirty),
        .rd_tag   (rd_tag),
        .rd_data  (rd_data),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_tag   (wr_tag),
        .wr_data  (wr_data),
        .wr_dirty (wr_dirty),
        .cln_en   (cln_en),
        .cln_idx  (cln_idx),
        .clr_all  (clr_all)
    );

    dc_lookup #(.TAG_W(TAG_W)) u_lookup (
        .req_tag      (cur_tag),
        .rd_valid     (rd_valid),
        .rd_dirty     (rd_dirty),
        .rd_tag       (rd_tag),
        .hit          (hit),
        .victim_dirty (victim_dirty)
    );

    dc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl_disable  (ctl_disable),
        .ctl_wback    (ctl_wback),
        .cmd_inval    (cmd_inval),
        .cmd_flush    (cmd_flush),
        .req_valid    (req_valid),
        .req_we       (req_we),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .busy         (busy),
        .rsp_valid    (rsp_valid),
        .rsp_err      (rsp_err),
        .rsp_rdata    (rsp_rdata),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_ack      (mem_ack),
        .mem_rdata    (mem_rdata),
        .rd_idx       (rd_idx),
        .cur_tag      (cur_tag),
        .rd_tag       (rd_tag),
        .rd_data      (rd_data),
        .rd_valid     (rd_valid),
        .rd_dirty     (rd_dirty),
        .hit          (hit),
        .victim_dirty (victim_dirty),
        .wr_en        (wr_en),
        .wr_idx       (wr_idx),
        .wr_tag       (wr_tag),
        .wr_data      (wr_data),
        .wr_dirty     (wr_dirty),
        .cln_en       (cln_en),
        .cln_idx      (cln_idx),
        .clr_all      (clr_all)
    );

endmodule

// File: rtl/dc_chk.sv
// Module: protocol checker for the data cache, bound to its top.
// Observes only top-level ports.
module dc_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_off,
    input logic              cmd_inval,
    input logic              cmd_flush,
    input logic              busy,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ack
);
    // R1: leaving reset finds the block idle with no memory request.
    a_r1_idle_out_of_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!busy && !mem_req && !rsp_valid));

    // R9: a pending memory request keeps its fields until acknowledged.
    a_r9_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)
                                   && $stable(mem_we) && $stable(mem_wdata)));

    // R9: memory traffic only happens while busy is reported.
    a_r9_busy_on_mem: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // R9: completion pulse lasts one cycle.
    a_r9_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R8: a misaligned request completes next cycle as an error, no memory.
    a_r8_misaligned: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && !cmd_inval && !cmd_flush && req_off != 2'b00)
        |=> (rsp_valid && rsp_err && !mem_req));

    // R8: memory addresses are always word aligned.
    a_r8_mem_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

endmodule

bind dcache_wb dc_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_off   (req_addr[1:0]),
    .cmd_inval (cmd_inval),
    .cmd_flush (cmd_flush),
    .busy      (busy),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack)
);

// File: tb/sim_dcache_wb.sv
`timescale 1ns/1ps
module sim_dcache_wb;
    localparam time HALF = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_disable = 1'b0;
    logic        ctl_wback = 1'b1;
    logic        cmd_inval = 1'b0;
    logic        cmd_flush = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_we = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        busy, rsp_valid, rsp_err, mem_req, mem_we;
    logic [31:0] rsp_rdata, mem_addr, mem_wdata;
    logic        mem_ack;
    logic [31:0] mem_rdata;

    int checks = 0;
    int fails  = 0;

    always #HALF clk = ~clk;

    dcache_wb u0 (
        .clk(clk), .rst_n(rst_n), .ctl_disable(ctl_disable), .ctl_wback(ctl_wback),
        .cmd_inval(cmd_inval), .cmd_flush(cmd_flush), .req_valid(req_valid),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // Backing memory model: 256 words, ack one cycle after request.
    logic [31:0] bmem [256];
    logic [31:0] wlog [8];
    int mrd, mwr;
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) bmem[i] <= 32'hA000_0000 + i;
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
            mrd <= 0;
            mwr <= 0;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                bmem[mem_addr[9:2]] <= mem_wdata;
                wlog[mwr % 8] <= mem_addr;
                mwr <= mwr + 1;
            end else begin
                mem_rdata <= bmem[mem_addr[9:2]];
                mrd <= mrd + 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One access through the core port; returns data, error and traffic.
    task automatic access(input logic we, input logic [31:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output logic er,
                          output int nrd, output int nwr);
        int r0, w0;
        @(negedge clk);
        r0 = mrd; w0 = mwr;
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        do @(negedge clk); while (!rsp_valid);
        rd = rsp_rdata; er = rsp_err;
        req_valid = 1'b0;
        @(negedge clk);
        chk("R9 rsp one cycle", {31'd0, rsp_valid}, 32'd0);
        nrd = mrd - r0; nwr = mwr - w0;
    endtask

    task automatic command(input logic inv, input logic fl, output int nrd, output int nwr);
        int r0, w0;
        @(negedge clk);
        r0 = mrd; w0 = mwr;
        cmd_inval = inv; cmd_flush = fl;
        do @(negedge clk); while (!rsp_valid);
        cmd_inval = 1'b0; cmd_flush = 1'b0;
        @(negedge clk);
        nrd = mrd - r0; nwr = mwr - w0;
    endtask

    // Full check of a single access.
    task automatic step(input string tag, input logic we, input logic [31:0] a,
                        input logic [31:0] d, input logic [31:0] exp_rd,
                        input int exp_nrd, input int exp_nwr, input logic exp_err);
        logic [31:0] rd; logic er; int nr, nw;
        access(we, a, d, rd, er, nr, nw);
        if (!we && !exp_err) chk({tag, " rdata"}, rd, exp_rd);
        chk({tag, " err"}, {31'd0, er}, {31'd0, exp_err});
        chk({tag, " mem reads"}, nr, exp_nrd);
        chk({tag, " mem writes"}, nw, exp_nwr);
    endtask

    typedef struct packed {
        logic        we;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [31:0] rdata;
        logic [3:0]  nrd;
        logic [3:0]  nwr;
        logic        err;
    } vec_t;

    // Write-back mode sequence: R11 fill, R2 dirty hits, R3/R10 conflict, R8 alignment.
    localparam vec_t VECS [12] = '{
        '{1'b0, 32'h010, 32'h0,         32'hA000_0004, 4'd1, 4'd0, 1'b0},
        '{1'b0, 32'h010, 32'h0,         32'hA000_0004, 4'd0, 4'd0, 1'b0},
        '{1'b1, 32'h010, 32'h1111_1111, 32'h0,         4'd0, 4'd0, 1'b0},
        '{1'b0, 32'h010, 32'h0,         32'h1111_1111, 4'd0, 4'd0, 1'b0},
        '{1'b0, 32'h050, 32'h0,         32'hA000_0014, 4'd1, 4'd1, 1'b0},
        '{1'b0, 32'h010, 32'h0,         32'h1111_1111, 4'd1, 4'd0, 1'b0},
        '{1'b1, 32'h014, 32'h2222_2222, 32'h0,         4'd0, 4'd0, 1'b0},
        '{1'b0, 32'h014, 32'h0,         32'h2222_2222, 4'd0, 4'd0, 1'b0},
        '{1'b0, 32'h012, 32'h0,         32'h0,         4'd0, 4'd0, 1'b1},
        '{1'b1, 32'h011, 32'h5A5A_5A5A, 32'h0,         4'd0, 4'd0, 1'b1},
        '{1'b0, 32'h014, 32'h0,         32'h2222_2222, 4'd0, 4'd0, 1'b0},
        '{1'b0, 32'h3C0, 32'h0,         32'hA000_00F0, 4'd1, 4'd0, 1'b0}
    };

    initial begin : watchdog
        #(HALF * 2 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : main
        int nr, nw, w0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk("R1 mem_req", {31'd0, mem_req}, 32'd0);

        // Table walk: R1 first miss, R2, R3, R8, R10, R11
        for (int i = 0; i < 12; i++) begin
            step($sformatf("R2/R3/R8/R10/R11 vec%0d", i), VECS[i].we, VECS[i].addr,
                 VECS[i].wdata, VECS[i].rdata, int'(VECS[i].nrd), int'(VECS[i].nwr),
                 VECS[i].err);
        end
        chk("R3 evicted addr", wlog[0], 32'h010);

        // R4 write-through
        ctl_wback = 1'b0;
        step("R4 wt miss store", 1'b1, 32'h020, 32'h3333_3333, 32'h0, 0, 1, 1'b0);
        step("R4 no allocate", 1'b0, 32'h020, 32'h0, 32'h3333_3333, 1, 0, 1'b0);
        step("R4 wt hit store", 1'b1, 32'h020, 32'h4444_4444, 32'h0, 0, 1, 1'b0);
        step("R4 wt hit load", 1'b0, 32'h020, 32'h0, 32'h4444_4444, 0, 0, 1'b0);
        ctl_wback = 1'b1;
        step("R4 clean eviction", 1'b0, 32'h060, 32'h0, 32'hA000_0018, 1, 0, 1'b0);

        // R5 disabled bypass
        step("R5 wb store", 1'b1, 32'h030, 32'h5555_5555, 32'h0, 0, 0, 1'b0);
        ctl_disable = 1'b1;
        step("R5 bypass load", 1'b0, 32'h030, 32'h0, 32'hA000_000C, 1, 0, 1'b0);
        step("R5 bypass store", 1'b1, 32'h030, 32'h6666_6666, 32'h0, 0, 1, 1'b0);
        ctl_disable = 1'b0;
        step("R5 array untouched", 1'b0, 32'h030, 32'h0, 32'h5555_5555, 0, 0, 1'b0);

        // R6 invalidate discards dirty data
        command(1'b1, 1'b0, nr, nw);
        chk("R6 inval traffic", nr + nw, 0);
        step("R6 refetch", 1'b0, 32'h030, 32'h0, 32'h6666_6666, 1, 0, 1'b0);

        // R7 flush order and final invalidation
        step("R7 dirty idx2", 1'b1, 32'h008, 32'h7777_7777, 32'h0, 0, 0, 1'b0);
        step("R7 dirty idx7", 1'b1, 32'h01C, 32'h8888_8888, 32'h0, 0, 0, 1'b0);
        step("R7 dirty idx1", 1'b1, 32'h004, 32'h9999_9999, 32'h0, 0, 0, 1'b0);
        w0 = mwr;
        command(1'b0, 1'b1, nr, nw);
        chk("R7 flush writes", nw, 3);
        chk("R7 flush reads", nr, 0);
        chk("R7 order first", wlog[w0 % 8], 32'h004);
        chk("R7 order second", wlog[(w0 + 1) % 8], 32'h008);
        chk("R7 order third", wlog[(w0 + 2) % 8], 32'h01C);
        step("R7 written and invalid", 1'b0, 32'h008, 32'h0, 32'h7777_7777, 1, 0, 1'b0);
        step("R7 clean line dropped", 1'b0, 32'h030, 32'h0, 32'h6666_6666, 1, 0, 1'b0);
        step("R7 idx7 in memory", 1'b0, 32'h01C, 32'h0, 32'h8888_8888, 1, 0, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule